// File: doc/BRIEF.md
# Port Write Cache with Coherent Read Line

This block sits in front of a memory command sink on one port of a shared memory system. Users issue single commands: an enable, a write flag, a line address, a full line of write data and a per-byte write enable mask. Writes are not forwarded right away. They are merged into one pending line held in registers, and the byte enables of every merged write are gathered into one accumulated mask. The pending line is sent to memory later, as one masked write. This happens when a write arrives for a different line, when a read misses on the same line, or when the port has gone a programmable number of cycles without a new write.

Reads are served from a single cached read line. A read to the cached line is answered one cycle after it is accepted, with no memory access. A read to any other line fetches that line from memory and replaces the cached copy. When the coherence option is on, every write to the cached read line also patches that copy at once, so later hits see the new bytes before they reach memory. When the option is off, such hits return the older copy.

The memory side uses a request that is held until it is acknowledged. Read data comes back later with its own valid strobe. While the block is busy with memory, or owes memory a timed flush, it raises a busy flag, and the user must hold off new commands.

Top module: `port_wcache`

## Requirements
- R1: After reset, cmd_busy, mem_req and rd_valid are all low.
- R2: Writes to the line that is already pending are merged without any memory access. Later bytes replace earlier ones, and the mask sent to memory is the OR of all merged masks.
- R3: A pending line is written to memory once TOUT idle cycles have passed since its last write, and not before. TOUT defaults to 255.
- R4: A write to a line other than the pending one sends the old pending line to memory at once. The new write stays pending.
- R5: Byte enable bit i covers data bits 8i+7 down to 8i, so bit 0 is the least significant byte. Memory bytes whose enable was never set keep their old contents.
- R6: A read to the cached read line returns its data with rd_valid one cycle after acceptance, with no memory request.
- R7: A read to any other line fetches that line from memory, returns it, and makes it the cached read line.
- R8: A read miss to the line that has a pending write first sends that write to memory. The data returned then includes the write.
- R9: With COHERENT=1, a write to the cached read line updates that line at once. A read one idle cycle later hits and sees the new bytes, while memory still holds the old line.
- R10: With TOUT=0, every write reaches memory within a few cycles of being accepted.
- R11: With COHERENT=0, a read hit after a write to the cached line returns the line as it was fetched (stale data).
- R12: A memory request keeps its address and direction stable until it is acknowledged. cmd_busy is high whenever a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en | input | 1 | Command strobe, taken when cmd_busy is low |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Line address |
| cmd_wdata | input | DW | Write data |
| cmd_wmask | input | DW/8 | Byte enables for the write |
| cmd_busy | output | 1 | Commands are not taken while high |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DW | Read data |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_wr | output | 1 | Request direction, 1 = write |
| mem_addr | output | AW | Request line address |
| mem_wdata | output | DW | Flushed line data |
| mem_wmask | output | DW/8 | Accumulated byte enables of the flush |
| mem_ack | input | 1 | Memory has taken the request |
| mem_rvalid | input | 1 | Read data from memory is valid |
| mem_rdata | input | DW | Read data from memory |

## Verification
The bench checks the exact window of the inactivity timer. A design that counts short flushes before TOUT idle cycles have passed, and one that never reloads the timer leaves a line pending forever. It checks that disjoint masks merge into one memory write that leaves the never-enabled bytes alone, which catches a mask that is overwritten instead of ORed. It checks a read miss on the line with a pending write, where a design that skips the flush returns memory's old bytes. It also compares coherent and non-coherent read hits just after a write, where a wrong patch of the read line shows up either as stale data or as an extra memory fetch.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [1:0] {
    WC_IDLE   = 2'd0,
    WC_FLUSH  = 2'd1,
    WC_RDREQ  = 2'd2,
    WC_RDWAIT = 2'd3
  } wc_state_e;
endpackage

// File: rtl/wc_byte_merge.sv
module wc_byte_merge #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   upd,
  input  logic [DW/8-1:0] mask,
  output logic [DW-1:0]   merged
);
  localparam int BW = DW / 8;

  // lane g takes the update byte only when its enable is set
  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign merged[g*8 +: 8] = mask[g] ? upd[g*8 +: 8] : base[g*8 +: 8];
  end
endmodule

// File: rtl/wc_flush_timer.sv
module wc_flush_timer #(
  parameter int TOUT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CW = (TOUT > 0) ? $clog2(TOUT + 1) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TOUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/port_wcache.sv
module port_wcache #(
  parameter int AW       = 8,
  parameter int DW       = 64,
  parameter int TOUT     = 255,
  parameter bit COHERENT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_en,
  input  logic            cmd_wr,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [DW/8-1:0] cmd_wmask,
  output logic            cmd_busy,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            mem_req,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wmask,
  input  logic            mem_ack,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata
);
  import wc_pkg::*;

  localparam int BW = DW / 8;

  wc_state_e     st;
  logic          w_valid;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic [BW-1:0] w_mask;
  logic          r_valid;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_data;
  logic          pend_rd;
  logic [AW-1:0] rd_addr_q;

  logic          tmr_exp;
  logic          flush_due;
  logic          wr_acc;
  logic          rd_acc;
  logic          w_hit;
  logic          r_hit;
  logic [DW-1:0] w_merged;
  logic [DW-1:0] r_merged;

  assign flush_due = (st == WC_IDLE) && w_valid && tmr_exp;
  assign cmd_busy  = (st != WC_IDLE) || (w_valid && tmr_exp);
  assign wr_acc    = cmd_en && !cmd_busy && cmd_wr;
  assign rd_acc    = cmd_en && !cmd_busy && !cmd_wr;
  assign w_hit     = w_valid && (w_addr == cmd_addr);
  assign r_hit     = r_valid && (r_addr == cmd_addr);

  wc_byte_merge #(.DW(DW)) i_wmerge (
    .base  (w_data),
    .upd   (cmd_wdata),
    .mask  (cmd_wmask),
    .merged(w_merged)
  );

  wc_byte_merge #(.DW(DW)) i_rmerge (
    .base  (r_data),
    .upd   (cmd_wdata),
    .mask  (cmd_wmask),
    .merged(r_merged)
  );

  wc_flush_timer #(.TOUT(TOUT)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (wr_acc),
    .tick   (st == WC_IDLE),
    .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WC_IDLE;
      w_valid   <= 1'b0;
      w_addr    <= '0;
      w_data    <= '0;
      w_mask    <= '0;
      r_valid   <= 1'b0;
      r_addr    <= '0;
      r_data    <= '0;
      pend_rd   <= 1'b0;
      rd_addr_q <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      mem_req   <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wmask <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        WC_IDLE: begin
          if (flush_due) begin
            // inactivity flush of the pending line
            mem_req   <= 1'b1;
            mem_wr    <= 1'b1;
            mem_addr  <= w_addr;
            mem_wdata <= w_data;
            mem_wmask <= w_mask;
            w_valid   <= 1'b0;
            w_mask    <= '0;
            pend_rd   <= 1'b0;
            st        <= WC_FLUSH;
          end else if (wr_acc) begin
            if (COHERENT && r_hit) begin
              r_data <= r_merged;
            end
            w_addr  <= cmd_addr;
            w_data  <= w_merged;
            w_valid <= 1'b1;
            if (!w_valid || w_hit) begin
              w_mask <= w_mask | cmd_wmask;
            end else begin
              // line change: old line leaves, new one stays pending
              mem_req   <= 1'b1;
              mem_wr    <= 1'b1;
              mem_addr  <= w_addr;
              mem_wdata <= w_data;
              mem_wmask <= w_mask;
              w_mask    <= cmd_wmask;
              pend_rd   <= 1'b0;
              st        <= WC_FLUSH;
            end
          end else if (rd_acc) begin
            if (r_hit) begin
              rd_valid <= 1'b1;
              rd_data  <= r_data;
            end else begin
              rd_addr_q <= cmd_addr;
              r_valid   <= 1'b0;
              mem_req   <= 1'b1;
              if (w_hit) begin
                // keep memory order: pending write goes first
                mem_wr    <= 1'b1;
                mem_addr  <= w_addr;
                mem_wdata <= w_data;
                mem_wmask <= w_mask;
                w_valid   <= 1'b0;
                w_mask    <= '0;
                pend_rd   <= 1'b1;
                st        <= WC_FLUSH;
              end else begin
                mem_wr   <= 1'b0;
                mem_addr <= cmd_addr;
                st       <= WC_RDREQ;
              end
            end
          end
        end
        WC_FLUSH: begin
          if (mem_ack) begin
            if (pend_rd) begin
              mem_wr   <= 1'b0;
              mem_addr <= rd_addr_q;
              pend_rd  <= 1'b0;
              st       <= WC_RDREQ;
            end else begin
              mem_req <= 1'b0;
              st      <= WC_IDLE;
            end
          end
        end
        WC_RDREQ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= WC_RDWAIT;
          end
        end
        WC_RDWAIT: begin
          if (mem_rvalid) begin
            r_data   <= mem_rdata;
            r_addr   <= rd_addr_q;
            r_valid  <= 1'b1;
            rd_valid <= 1'b1;
            rd_data  <= mem_rdata;
            st       <= WC_IDLE;
          end
        end
        default: st <= WC_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wr));

  // R12
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cmd_busy);

  // R8
  rd_order_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_wr |-> !(w_valid && (w_addr == mem_addr)));

  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !mem_req);

endmodule

// File: tb/test_port_wcache.sv
module test_mem_model #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wmask,
  output logic            ack,
  output logic            rvalid,
  output logic [DW-1:0]   rdata,
  output logic [15:0]     wr_cnt,
  output logic [15:0]     rd_cnt
);
  logic [DW-1:0] mem [16];
  logic          stage;
  logic [DW-1:0] stage_d;

  function automatic logic [DW-1:0] seed(int i);
    logic [DW-1:0] v;
    for (int b = 0; b < DW/8; b++) v[b*8 +: 8] = 8'(i*16 + b + 1);
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0; rvalid <= 1'b0; stage <= 1'b0; stage_d <= '0;
      rdata <= '0; wr_cnt <= '0; rd_cnt <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= seed(i);
    end else begin
      ack    <= 1'b0;
      rvalid <= stage;
      rdata  <= stage_d;
      stage  <= 1'b0;
      if (req && !ack) begin
        ack <= 1'b1;
        if (wr) begin
          for (int b = 0; b < DW/8; b++)
            if (wmask[b]) mem[addr[3:0]][b*8 +: 8] <= wdata[b*8 +: 8];
          wr_cnt <= wr_cnt + 1'b1;
        end else begin
          stage   <= 1'b1;
          stage_d <= mem[addr[3:0]];
          rd_cnt  <= rd_cnt + 1'b1;
        end
      end
    end
  end
endmodule

module test_port_wcache;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int BW = DW / 8;
  localparam int TA = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // instance A: TA cycle timeout, coherent
  logic a_en = 0, a_wr = 0;
  logic [AW-1:0] a_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic [BW-1:0] a_wmask = '0;
  logic a_busy, a_rdv, a_req, a_mwr, a_ack, a_rv;
  logic [DW-1:0] a_rdata, a_mwdata, a_mrdata;
  logic [AW-1:0] a_maddr;
  logic [BW-1:0] a_mwmask;
  logic [15:0] a_wcnt, a_rcnt;

  // instance B: zero timeout, not coherent
  logic b_en = 0, b_wr = 0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [BW-1:0] b_wmask = '0;
  logic b_busy, b_rdv, b_req, b_mwr, b_ack, b_rv;
  logic [DW-1:0] b_rdata, b_mwdata, b_mrdata;
  logic [AW-1:0] b_maddr;
  logic [BW-1:0] b_mwmask;
  logic [15:0] b_wcnt, b_rcnt;

  port_wcache #(.AW(AW), .DW(DW), .TOUT(TA), .COHERENT(1'b1)) i_port_wcache (
    .clk(clk), .rst(rst), .cmd_en(a_en), .cmd_wr(a_wr), .cmd_addr(a_addr),
    .cmd_wdata(a_wdata), .cmd_wmask(a_wmask), .cmd_busy(a_busy),
    .rd_valid(a_rdv), .rd_data(a_rdata), .mem_req(a_req), .mem_wr(a_mwr),
    .mem_addr(a_maddr), .mem_wdata(a_mwdata), .mem_wmask(a_mwmask),
    .mem_ack(a_ack), .mem_rvalid(a_rv), .mem_rdata(a_mrdata));

  test_mem_model #(.AW(AW), .DW(DW)) i_mem_a (
    .clk(clk), .rst(rst), .req(a_req), .wr(a_mwr), .addr(a_maddr),
    .wdata(a_mwdata), .wmask(a_mwmask), .ack(a_ack), .rvalid(a_rv),
    .rdata(a_mrdata), .wr_cnt(a_wcnt), .rd_cnt(a_rcnt));

  port_wcache #(.AW(AW), .DW(DW), .TOUT(0), .COHERENT(1'b0)) i_port_wcache_nc (
    .clk(clk), .rst(rst), .cmd_en(b_en), .cmd_wr(b_wr), .cmd_addr(b_addr),
    .cmd_wdata(b_wdata), .cmd_wmask(b_wmask), .cmd_busy(b_busy),
    .rd_valid(b_rdv), .rd_data(b_rdata), .mem_req(b_req), .mem_wr(b_mwr),
    .mem_addr(b_maddr), .mem_wdata(b_mwdata), .mem_wmask(b_mwmask),
    .mem_ack(b_ack), .mem_rvalid(b_rv), .mem_rdata(b_mrdata));

  test_mem_model #(.AW(AW), .DW(DW)) i_mem_b (
    .clk(clk), .rst(rst), .req(b_req), .wr(b_mwr), .addr(b_maddr),
    .wdata(b_mwdata), .wmask(b_mwmask), .ack(b_ack), .rvalid(b_rv),
    .rdata(b_mrdata), .wr_cnt(b_wcnt), .rd_cnt(b_rcnt));

  function automatic logic [DW-1:0] seed(int i);
    logic [DW-1:0] v;
    for (int b = 0; b < BW; b++) v[b*8 +: 8] = 8'(i*16 + b + 1);
    return v;
  endfunction

  function automatic logic [DW-1:0] bmerge(logic [DW-1:0] o, logic [DW-1:0] n,
                                           logic [BW-1:0] m);
    logic [DW-1:0] v = o;
    for (int b = 0; b < BW; b++) if (m[b]) v[b*8 +: 8] = n[b*8 +: 8];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_cmd(bit wr, int ad, logic [DW-1:0] d, logic [BW-1:0] m);
    while (a_busy) @(negedge clk);
    a_en = 1; a_wr = wr; a_addr = AW'(ad); a_wdata = d; a_wmask = m;
    @(negedge clk);
    a_en = 0;
  endtask

  task automatic a_read(int ad, output logic [DW-1:0] d, output int lat);
    a_cmd(1'b0, ad, '0, '0);
    lat = 1;
    while (!a_rdv && lat < 40) begin @(negedge clk); lat++; end
    d = a_rdata;
  endtask

  task automatic b_cmd(bit wr, int ad, logic [DW-1:0] d, logic [BW-1:0] m);
    while (b_busy) @(negedge clk);
    b_en = 1; b_wr = wr; b_addr = AW'(ad); b_wdata = d; b_wmask = m;
    @(negedge clk);
    b_en = 0;
  endtask

  task automatic b_read(int ad, output logic [DW-1:0] d, output int lat);
    b_cmd(1'b0, ad, '0, '0);
    lat = 1;
    while (!b_rdv && lat < 40) begin @(negedge clk); lat++; end
    d = b_rdata;
  endtask

  task automatic t_reset();
    chk(!a_busy, "R1 busy", DW'(a_busy), '0);
    chk(!a_req, "R1 mem_req", DW'(a_req), '0);
    chk(!a_rdv && !b_rdv, "R1 rd_valid", DW'(a_rdv), '0);
  endtask

  task automatic t_merge();
    logic [DW-1:0] d1 = 64'hDEAD_BEEF_CAFE_F00D;
    logic [DW-1:0] d2 = 64'h1122_3344_5566_7788;
    logic [DW-1:0] exp;
    a_cmd(1'b1, 2, d1, 8'h0F);
    a_cmd(1'b1, 2, d2, 8'h31);
    chk(a_wcnt == 0, "R2 no access on merge", DW'(a_wcnt), '0);
    repeat (12) @(negedge clk);
    chk(a_wcnt == 0, "R3 not before timeout", DW'(a_wcnt), '0);
    repeat (12) @(negedge clk);
    chk(a_wcnt == 1, "R3 flushed after timeout", DW'(a_wcnt), 64'd1);
    exp = bmerge(bmerge(seed(2), d1, 8'h0F), d2, 8'h31);
    chk(i_mem_a.mem[2] == exp, "R2 merged line", i_mem_a.mem[2], exp);
    chk(i_mem_a.mem[2][63:48] == seed(2)[63:48], "R5 untouched bytes",
        DW'(i_mem_a.mem[2][63:48]), DW'(seed(2)[63:48]));
  endtask

  task automatic t_line_change();
    logic [DW-1:0] d3 = 64'hA5A5_0101_5A5A_0202;
    logic [DW-1:0] d4 = 64'h0000_0000_0000_00EE;
    a_cmd(1'b1, 3, d3, 8'hFF);
    a_cmd(1'b1, 4, d4, 8'h01);
    chk(a_busy, "R12 busy during flush", DW'(a_busy), 64'd1);
    repeat (3) @(negedge clk);
    chk(a_wcnt == 2, "R4 old line flushed", DW'(a_wcnt), 64'd2);
    chk(i_mem_a.mem[3] == d3, "R4 old line data", i_mem_a.mem[3], d3);
    chk(i_mem_a.mem[4] == seed(4), "R4 new line still pending",
        i_mem_a.mem[4], seed(4));
    repeat (40) @(negedge clk);
    chk(i_mem_a.mem[4] == bmerge(seed(4), d4, 8'h01), "R5 byte 0 lane",
        i_mem_a.mem[4], bmerge(seed(4), d4, 8'h01));
  endtask

  task automatic t_reads();
    logic [DW-1:0] d;
    int lat;
    logic [15:0] rc;
    a_read(5, d, lat);
    chk(d == seed(5), "R7 miss data", d, seed(5));
    chk(a_rcnt == 1, "R7 memory read issued", DW'(a_rcnt), 64'd1);
    rc = a_rcnt;
    a_read(5, d, lat);
    chk(d == seed(5) && lat == 1, "R6 hit data and latency", d, seed(5));
    chk(a_rcnt == rc, "R6 no memory read", DW'(a_rcnt), DW'(rc));
  endtask

  task automatic t_coherent();
    logic [DW-1:0] w = 64'h7700_0000_0000_0000;
    logic [DW-1:0] d;
    logic [DW-1:0] exp;
    int lat;
    logic [15:0] rc = a_rcnt;
    a_cmd(1'b1, 5, w, 8'h80);
    @(negedge clk);
    a_read(5, d, lat);
    exp = bmerge(seed(5), w, 8'h80);
    chk(d == exp && lat == 1, "R9 coherent hit", d, exp);
    chk(a_rcnt == rc, "R9 no fetch", DW'(a_rcnt), DW'(rc));
    chk(i_mem_a.mem[5] == seed(5), "R9 memory not yet written",
        i_mem_a.mem[5], seed(5));
    repeat (40) @(negedge clk);
  endtask

  task automatic t_read_after_pending();
    logic [DW-1:0] w = 64'h0000_0000_0000_BEEF;
    logic [DW-1:0] d;
    logic [DW-1:0] exp;
    int lat;
    logic [15:0] wc = a_wcnt;
    a_cmd(1'b1, 6, w, 8'h03);
    a_read(6, d, lat);
    exp = bmerge(seed(6), w, 8'h03);
    chk(d == exp, "R8 read sees pending write", d, exp);
    chk(a_wcnt == wc + 1, "R8 write flushed first", DW'(a_wcnt), DW'(wc + 1));
  endtask

  task automatic t_nc();
    logic [DW-1:0] x = 64'hFEDC_BA98_7654_3210;
    logic [DW-1:0] d;
    int lat;
    b_read(9, d, lat);
    chk(d == seed(9), "R7 fill on second port", d, seed(9));
    b_cmd(1'b1, 9, x, 8'hFF);
    repeat (5) @(negedge clk);
    chk(b_wcnt == 1 && i_mem_b.mem[9] == x, "R10 prompt write",
        i_mem_b.mem[9], x);
    b_read(9, d, lat);
    chk(d == seed(9) && lat == 1, "R11 stale hit", d, seed(9));
    chk(b_rcnt == 1, "R11 no refetch", DW'(b_rcnt), 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_merge();
    t_line_change();
    t_reads();
    t_coherent();
    t_read_after_pending();
    t_nc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule